// File: doc/BRIEF.md
# Link Activity Meter

The link activity meter is a per-port statistics block. For one measurement window it counts either the clock cycles the link spends in a chosen power or training state, or the payload volume moved in a chosen direction. Software sets a report code, a window length and a run bit in one 32-bit control word. It then reads a 64-bit result as two 32-bit words.

The status inputs are sampled every clock: eight link-state flags and four payload strobes, with each strobe worth one 16-byte unit. A window is either manual, running until software clears the run bit, or timed. A timed window is measured in pulses of a microsecond tick input and ends by itself. Starting a new measurement clears the previous result.

Top module: `link_stat_meter`

## Requirements
- R1: Control word at address 0: report code in bits 31:24, window code in bits 15:8, run bit in bit 0. All other bits read as zero.
- R2: A write to address 0 with bit 0 set while idle starts a window. It loads both codes, clears the result, and counts from the next cycle; the start cycle itself is not counted.
- R3: Residency codes count one per cycle while running, using link_status bits. 0x00 counts every cycle, 0x01 bit1 (TX L0s), 0x02 bit2 (RX L0s), 0x03 bit0 (L0), 0x04 bit3 (L1), 0x05 bit4 (L1.1), 0x06 bit5 (L1.2), 0x07 bit6 (recovery/config), 0x08 bit1 AND bit2, and 0x09 bit7 (L1 aux).
- R4: Payload codes 0x20, 0x21, 0x22 and 0x23 add one per cycle in which payload_pulse bit 0, 1, 2 or 3 is high: TX data, RX data, TX alternate protocol and RX alternate protocol, each unit being 16 bytes.
- R5: Any other report code counts nothing, so the result stays zero.
- R6: Window code 0x00 is manual. It runs until a write to address 0 with bit 0 clear, and the cycle of that write is still counted.
- R7: Timed window codes, in us_tick pulses: 0x01 1000, 0x02 10000, 0x03 100000, 0x04 1000000, 0x05 2000000, 0x06 4000000, 0xFF 4. The window ends in the cycle carrying the last tick, and that cycle is counted. The run bit then reads 0 and the result holds until the next start.
- R8: Window codes not listed in R6 or R7 behave as manual.
- R9: While running, a write with bit 0 set is ignored, and a stop leaves both codes unchanged. A timer expiry ends the window even when such a write falls in the same cycle.
- R10: A read (rd_en) returns data on rdata one cycle later, and rdata holds between reads. Address 1 returns the low word and snapshots the high word; address 2 returns that snapshot; address 3 returns zero.
- R11: Writes to addresses 1, 2 and 3 have no effect.
- R12: A synchronous active-low reset clears the control word, the result, the snapshot and rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| link_status | input | 8 | Per-cycle link state flags |
| payload_pulse | input | 4 | Per-cycle payload unit strobes |
| us_tick | input | 1 | One-cycle pulse each microsecond |

## Verification
Two functions can land in the same cycle: the timer expiring on its final tick, and a software write to the control word. The bench drives that write on exactly the cycle of the fourth tick of a 4 us window. It does this once with the run bit set, where the write must lose to the expiry, and once with the run bit clear, where both end the window. In both cases the result must be 4 and the run bit must read 0. A result read issued while counting is also compared cycle by cycle against the reference model, to show that the read returns the value from before that cycle's increment.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LOW  = 2'd1;
    localparam logic [ADDR_W-1:0] A_HIGH = 2'd2;

    typedef struct packed {
        logic [7:0] report;
        logic [7:0] dur;
        logic       run;
    } ctrl_t;

    // residency report codes
    localparam logic [7:0] RPT_ANY      = 8'h00;
    localparam logic [7:0] RPT_TXL0S    = 8'h01;
    localparam logic [7:0] RPT_RXL0S    = 8'h02;
    localparam logic [7:0] RPT_L0       = 8'h03;
    localparam logic [7:0] RPT_L1       = 8'h04;
    localparam logic [7:0] RPT_L1A      = 8'h05;
    localparam logic [7:0] RPT_L1B      = 8'h06;
    localparam logic [7:0] RPT_RCV      = 8'h07;
    localparam logic [7:0] RPT_BOTHL0S  = 8'h08;
    localparam logic [7:0] RPT_L1AUX    = 8'h09;
    // payload report codes
    localparam logic [7:0] RPT_TX_DATA  = 8'h20;
    localparam logic [7:0] RPT_RX_DATA  = 8'h21;
    localparam logic [7:0] RPT_TX_ALT   = 8'h22;
    localparam logic [7:0] RPT_RX_ALT   = 8'h23;

    // link_status bit positions
    localparam int ST_L0    = 0;
    localparam int ST_TXL0S = 1;
    localparam int ST_RXL0S = 2;
    localparam int ST_L1    = 3;
    localparam int ST_L1A   = 4;
    localparam int ST_L1B   = 5;
    localparam int ST_RCV   = 6;
    localparam int ST_L1AUX = 7;

    // window length in microsecond ticks; zero means manual
    function automatic logic [31:0] window_ticks(input logic [7:0] code,
                                                 input logic [31:0] us_per_ms);
        case (code)
            8'h01:   return us_per_ms;
            8'h02:   return us_per_ms * 32'd10;
            8'h03:   return us_per_ms * 32'd100;
            8'h04:   return us_per_ms * 32'd1000;
            8'h05:   return us_per_ms * 32'd2000;
            8'h06:   return us_per_ms * 32'd4000;
            8'hFF:   return 32'd4;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
    import lsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              expire,
    output ctrl_t             ctrl_q,
    output logic              start
);

    ctrl_t ctrl_d;
    logic  ctrl_wr;
    logic  unused_bits;

    assign unused_bits = ^{wdata[23:16], wdata[7:1]};
    assign ctrl_wr     = wr_en && (addr == A_CTRL);
    assign start       = ctrl_wr && wdata[0] && !ctrl_q.run;

    always_comb begin
        ctrl_d = ctrl_q;
        if (start) begin
            ctrl_d.report = wdata[31:24];
            ctrl_d.dur    = wdata[15:8];
            ctrl_d.run    = 1'b1;
        end else if (ctrl_q.run) begin
            if (ctrl_wr && !wdata[0]) begin
                ctrl_d.run = 1'b0;
            end
            if (expire) begin
                ctrl_d.run = 1'b0;
            end
        end else if (ctrl_wr) begin
            ctrl_d.report = wdata[31:24];
            ctrl_d.dur    = wdata[15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/lsm_window_timer.sv
module lsm_window_timer
    import lsm_pkg::*;
#(
    parameter int US_PER_MS = 1000,
    parameter int TIMER_W   = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       run,
    input  logic [7:0] dur,
    input  logic       us_tick,
    output logic       expire
);

    typedef struct packed {
        logic [TIMER_W-1:0] ticks;
    } tmr_t;

    tmr_t        tmr_d, tmr_q;
    logic [31:0] limit;
    logic        timed;

    assign limit  = window_ticks(dur, 32'(US_PER_MS));
    assign timed  = (limit != 32'd0);
    assign expire = run && us_tick && timed &&
                    (tmr_q.ticks == TIMER_W'(limit - 32'd1));

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.ticks = '0;
        end else if (run && us_tick && timed) begin
            tmr_d.ticks = tmr_q.ticks + TIMER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/lsm_event_sel.sv
module lsm_event_sel
    import lsm_pkg::*;
#(
    parameter int N_STATE = 8,
    parameter int N_PAY   = 4
) (
    input  logic [7:0]         report,
    input  logic [N_STATE-1:0] link_status,
    input  logic [N_PAY-1:0]   payload_pulse,
    output logic               hit
);

    logic [N_PAY-1:0] pay_sel;

    // one decoder per payload strobe
    for (genvar p = 0; p < N_PAY; p++) begin : g_pay
        assign pay_sel[p] = (report == (RPT_TX_DATA + 8'(p))) && payload_pulse[p];
    end

    always_comb begin
        case (report)
            RPT_ANY:     hit = 1'b1;
            RPT_TXL0S:   hit = link_status[ST_TXL0S];
            RPT_RXL0S:   hit = link_status[ST_RXL0S];
            RPT_L0:      hit = link_status[ST_L0];
            RPT_L1:      hit = link_status[ST_L1];
            RPT_L1A:     hit = link_status[ST_L1A];
            RPT_L1B:     hit = link_status[ST_L1B];
            RPT_RCV:     hit = link_status[ST_RCV];
            RPT_BOTHL0S: hit = link_status[ST_TXL0S] && link_status[ST_RXL0S];
            RPT_L1AUX:   hit = link_status[ST_L1AUX];
            default:     hit = |pay_sel;
        endcase
    end

endmodule

// File: rtl/lsm_result.sv
module lsm_result
    import lsm_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              hit,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    output logic [CNT_W-1:0]  count_q,
    output logic [WORD_W-1:0] rdata
);

    localparam int HI_W = CNT_W - WORD_W;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [HI_W-1:0]   snap;
        logic [WORD_W-1:0] rdata;
    } res_t;

    res_t              res_d, res_q;
    logic [WORD_W-1:0] ctrl_word;

    assign ctrl_word = WORD_W'({ctrl.report, 8'h00, ctrl.dur, 7'h00, ctrl.run});

    always_comb begin
        res_d = res_q;
        if (start) begin
            res_d.count = '0;
        end else if (run && hit) begin
            res_d.count = res_q.count + CNT_W'(1);
        end
        if (rd_en) begin
            case (addr)
                A_CTRL: res_d.rdata = ctrl_word;
                A_LOW: begin
                    res_d.rdata = res_q.count[WORD_W-1:0];
                    res_d.snap  = res_q.count[CNT_W-1:WORD_W];
                end
                A_HIGH:  res_d.rdata = WORD_W'(res_q.snap);
                default: res_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign count_q = res_q.count;
    assign rdata   = res_q.rdata;

endmodule

// File: rtl/link_stat_meter.sv
module link_stat_meter
    import lsm_pkg::*;
#(
    parameter int US_PER_MS = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [7:0]  link_status,
    input  logic [3:0]  payload_pulse,
    input  logic        us_tick
);

    localparam int TIMER_W = $clog2(US_PER_MS * 4000 + 1);
    localparam int CNT_W   = 64;

    ctrl_t             ctrl_q;
    logic              start;
    logic              expire;
    logic              hit;
    logic              run_q;
    logic [7:0]        report_q;
    logic [7:0]        dur_q;
    logic [CNT_W-1:0]  count_q;

    assign run_q    = ctrl_q.run;
    assign report_q = ctrl_q.report;
    assign dur_q    = ctrl_q.dur;

    lsm_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .expire (expire),
        .ctrl_q (ctrl_q),
        .start  (start)
    );

    lsm_window_timer #(
        .US_PER_MS (US_PER_MS),
        .TIMER_W   (TIMER_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (run_q),
        .dur     (dur_q),
        .us_tick (us_tick),
        .expire  (expire)
    );

    lsm_event_sel #(
        .N_STATE (8),
        .N_PAY   (4)
    ) u_sel (
        .report        (report_q),
        .link_status   (link_status),
        .payload_pulse (payload_pulse),
        .hit           (hit)
    );

    lsm_result #(
        .CNT_W  (CNT_W),
        .WORD_W (32)
    ) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (run_q),
        .hit     (hit),
        .rd_en   (rd_en),
        .addr    (addr),
        .ctrl    (ctrl_q),
        .count_q (count_q),
        .rdata   (rdata)
    );

endmodule

// File: rtl/lsm_checker.sv
module lsm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [1:0]  addr,
    input logic [31:0] rdata,
    input logic        run_q,
    input logic [7:0]  report_q,
    input logic [7:0]  dur_q,
    input logic [63:0] count_q
);

    function automatic logic known_code(input logic [7:0] c);
        return (c <= 8'h09) || (c >= 8'h20 && c <= 8'h23);
    endfunction

    // R2: a new window always begins from a zero result
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> count_q == 64'd0);

    // R5: unknown report codes never advance the result
    a_r5_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !known_code(report_q)) |=> count_q == $past(count_q));

    // R6: the result advances by at most one per cycle
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 64'd1));

    // R7: when no window runs the result is held (or cleared by a start)
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable(count_q) || count_q == 64'd0);

    // R9: codes stay fixed while a window runs
    a_r9_codes_locked: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(report_q) && $stable(dur_q));

    // R10: the unused address reads as zero
    a_r10_addr3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3) |=> rdata == 32'd0);

    // R12: reset clears run bit, result and read data
    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !run_q && count_q == 64'd0 && rdata == 32'd0);

endmodule

bind link_stat_meter lsm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .run_q    (run_q),
    .report_q (report_q),
    .dur_q    (dur_q),
    .count_q  (count_q)
);

// File: tb/link_stat_meter_tb_top.sv
`timescale 1ns/1ps
module link_stat_meter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [7:0]  link_status = 8'd0;
    logic [3:0]  payload_pulse = 4'd0;
    logic        us_tick = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    link_stat_meter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .link_status   (link_status),
        .payload_pulse (payload_pulse),
        .us_tick       (us_tick)
    );

    // ---------------- behavioural reference model ----------------
    longint unsigned m_count;
    logic [31:0]     m_hi;
    logic [31:0]     m_rdata;
    bit              m_run;
    logic [7:0]      m_rpt, m_dur;
    int unsigned     m_ticks;

    function automatic bit ref_hit(input logic [7:0] r, input logic [7:0] s, input logic [3:0] p);
        case (r)
            8'h00: return 1;
            8'h01: return s[1];
            8'h02: return s[2];
            8'h03: return s[0];
            8'h04: return s[3];
            8'h05: return s[4];
            8'h06: return s[5];
            8'h07: return s[6];
            8'h08: return s[1] & s[2];
            8'h09: return s[7];
            8'h20: return p[0];
            8'h21: return p[1];
            8'h22: return p[2];
            8'h23: return p[3];
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned ref_limit(input logic [7:0] d);
        case (d)
            8'h01: return 1000;
            8'h02: return 10000;
            8'h03: return 100000;
            8'h04: return 1000000;
            8'h05: return 2000000;
            8'h06: return 4000000;
            8'hFF: return 4;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit h, st;
        int unsigned lim;
        if (!rst_n) begin
            m_count = 0; m_hi = 0; m_rdata = 0; m_run = 0;
            m_rpt = 0; m_dur = 0; m_ticks = 0;
        end else begin
            h   = ref_hit(m_rpt, link_status, payload_pulse);
            lim = ref_limit(m_dur);
            st  = wr_en && addr == 2'd0 && wdata[0] && !m_run;
            if (rd_en) begin
                case (addr)
                    2'd0: m_rdata = {m_rpt, 8'h00, m_dur, 7'h00, m_run};
                    2'd1: begin m_rdata = m_count[31:0]; m_hi = m_count[63:32]; end
                    2'd2: m_rdata = m_hi;
                    default: m_rdata = 0;
                endcase
            end
            if (m_run && h) m_count++;
            if (st) begin
                m_count = 0; m_rpt = wdata[31:24]; m_dur = wdata[15:8];
                m_run = 1; m_ticks = 0;
            end else if (m_run) begin
                if (wr_en && addr == 2'd0 && !wdata[0]) m_run = 0;
                if (us_tick) begin
                    m_ticks++;
                    if (lim != 0 && m_ticks == lim) m_run = 0;
                end
            end else if (wr_en && addr == 2'd0) begin
                m_rpt = wdata[31:24]; m_dur = wdata[15:8];
            end
        end
    end

    // every-cycle comparison against the model (R10 read path)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rdata !== m_rdata) begin
                fails++;
                $display("FAIL R10 model compare: actual=%h expected=%h at %0t", rdata, m_rdata, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0; wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd0;
        v = rdata;
    endtask

    task automatic stop_run();
        wr(2'd0, 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R12 / R1: reset state
        rd(2'd0, v); chk("R12 ctrl after reset", v, 32'h0);
        rd(2'd1, v); chk("R12 low after reset", v, 32'h0);
        rd(2'd2, v); chk("R12 high after reset", v, 32'h0);

        // R6 / R3: manual, every cycle
        wr(2'd0, 32'h0000_0001);
        idle(20);
        stop_run();
        rd(2'd1, v); chk("R6 manual every-cycle count", v, 32'd21);
        rd(2'd2, v); chk("R10 high snapshot", v, 32'd0);

        // R11: writes to result addresses ignored
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R11 low unchanged", v, 32'd21);
        rd(2'd2, v); chk("R11 high unchanged", v, 32'd0);
        rd(2'd3, v); chk("R10 addr3 reads zero", v, 32'd0);

        // R3: L1 residency (bit3)
        wr(2'd0, 32'h0400_0001);
        link_status = 8'h08; idle(7);
        link_status = 8'h00; idle(5);
        stop_run();
        rd(2'd1, v); chk("R3 L1 residency", v, 32'd7);
        rd(2'd0, v); chk("R1 ctrl readback stopped", v, 32'h0400_0000);

        // R3: both-L0s (0x08) and TX L0s (0x01)
        for (int k = 0; k < 2; k++) begin
            wr(2'd0, (k == 0) ? 32'h0800_0001 : 32'h0100_0001);
            link_status = 8'h02; idle(3);
            link_status = 8'h04; idle(2);
            link_status = 8'h06; idle(4);
            link_status = 8'h00;
            stop_run();
            rd(2'd1, v);
            chk(k == 0 ? "R3 TX-and-RX L0s" : "R3 TX L0s", v, k == 0 ? 32'd4 : 32'd7);
        end

        // R4: RX data payload then RX alternate payload
        for (int k = 0; k < 2; k++) begin
            wr(2'd0, (k == 0) ? 32'h2100_0001 : 32'h2300_0001);
            payload_pulse = 4'b0010; idle(9);
            payload_pulse = 4'b1101; idle(6);
            payload_pulse = 4'b0000;
            stop_run();
            rd(2'd1, v);
            chk(k == 0 ? "R4 RX data units" : "R4 RX alt units", v, k == 0 ? 32'd9 : 32'd6);
        end

        // R5: unsupported report codes
        wr(2'd0, 32'h0A00_0001);
        link_status = 8'hFF; payload_pulse = 4'hF; idle(10);
        stop_run();
        link_status = 8'h00; payload_pulse = 4'h0;
        rd(2'd1, v); chk("R5 code 0x0A counts nothing", v, 32'd0);

        // R2: result cleared at start, start cycle not counted
        wr(2'd0, 32'h0000_0001);
        idle(5);
        stop_run();
        wr(2'd0, 32'h0000_0001);
        rd(2'd1, v); chk("R2 result cleared on start", v, 32'd0);
        stop_run();
        rd(2'd1, v); chk("R2 count after restart", v, 32'd2);

        // R7: 4 us window, tick every cycle
        us_tick = 1'b1;
        wr(2'd0, 32'h0000_FF01);
        idle(10);
        rd(2'd0, v); chk("R7 run bit self-clears", v, 32'h0000_FF00);
        rd(2'd1, v); chk("R7 4us count", v, 32'd4);
        idle(5);
        rd(2'd1, v); chk("R7 result holds", v, 32'd4);

        // R7: 4 us window, tick every third cycle
        us_tick = 1'b0;
        wr(2'd0, 32'h0000_FF01);
        for (int i = 0; i < 15; i++) begin
            us_tick = (i % 3 == 2);
            @(negedge clk);
        end
        us_tick = 1'b0;
        rd(2'd1, v); chk("R7 sparse tick window", v, 32'd12);

        // R7: 1 ms window, L0 residency
        us_tick = 1'b1; link_status = 8'h01;
        wr(2'd0, 32'h0300_0101);
        idle(1010);
        rd(2'd1, v); chk("R7 1ms L0 count", v, 32'd1000);
        link_status = 8'h00;

        // R9: expiry wins over a same-cycle write with bit0 set
        wr(2'd0, 32'h0000_FF01);
        idle(3);
        wr(2'd0, 32'h2000_0301);
        rd(2'd0, v); chk("R9 expiry vs write ctrl", v, 32'h0000_FF00);
        rd(2'd1, v); chk("R9 expiry vs write count", v, 32'd4);

        // R9: stop write on the expiry cycle
        wr(2'd0, 32'h0000_FF01);
        idle(3);
        stop_run();
        rd(2'd1, v); chk("R9 stop on expiry count", v, 32'd4);

        // R8: unlisted window code behaves as manual
        wr(2'd0, 32'h0000_0701);
        idle(10);
        rd(2'd0, v); chk("R8 unlisted window still runs", v, 32'h0000_0701);
        stop_run();
        us_tick = 1'b0;

        // R9: codes locked while running
        wr(2'd0, 32'h0400_0001);
        wr(2'd0, 32'h2000_0301);
        rd(2'd0, v); chk("R9 codes locked", v, 32'h0400_0001);
        stop_run();
        rd(2'd0, v); chk("R9 stop keeps codes", v, 32'h0400_0000);

        // R12: reset mid-run
        wr(2'd0, 32'h0000_0001);
        idle(5);
        rst_n = 1'b0; idle(1); rst_n = 1'b1;
        rd(2'd0, v); chk("R12 ctrl after mid reset", v, 32'h0);
        rd(2'd1, v); chk("R12 low after mid reset", v, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule